// File: doc/BRIEF.md
# Receive DMA Burst Sequencer for a Parallel Disk Bus

This block runs the host side of a drive-to-host DMA burst on a parallel disk-drive bus. Software arms a transfer by setting a pending flag, with the direction field at zero. The sequencer then waits for the drive to raise its DMA request and answers with an acknowledge. While the burst runs, it emits one strobe per data word toward the receive FIFO. The word rate depends on the transfer mode captured when the transfer starts. When the FIFO is full, the acknowledge stays up but the strobes stop, so the drive is stalled and no data is lost.

A host access to a drive register pauses a running burst. The acknowledge drops on the next clock and comes back only after the access reports completion. When the drive withdraws its request, the burst ends and the pending flag clears. One clock later the idle status rises, which tells software it may drain the words left in the FIFO by hand. A pulse on the drive's interrupt line is held as an end-of-transfer flag. That flag clears when the next transfer is armed.

Top module: `ata_rx_dma_seq`

## Requirements
- R1: A transfer leaves idle only when the pending flag is 1 and `cfg_dir` is 0. With `cfg_dir` at 1, the block stays idle with the acknowledge low, and the pending flag stays set.
- R2: `cfg_mode` is captured when a transfer is armed. With 0 (multiword), one word strobe is given for every `MW_DIV` qualifying cycles; the divider restarts after a pause. With 1 (ultra), every qualifying cycle strobes. A qualifying cycle is an active cycle with the request high and the FIFO not full. Changing `cfg_mode` during a transfer has no effect on it.
- R3: In the waiting state, the acknowledge rises on the clock after the request is seen high. Word strobes occur only while the acknowledge is high.
- R4: A register-access request during an active burst drives the acknowledge low and `paused` high on the next clock. No strobes occur while paused.
- R5: `reg_acc_done` while paused restores the acknowledge and clears `paused` on the next clock.
- R6: The request going low in an active, unpaused burst clears the pending flag and the acknowledge on the next clock.
- R7: `eot_sts` is set on the clock after `drv_intrq` is seen high. It stays set until a new transfer is armed.
- R8: `idle_sts` is high in the idle state. After completion it rises exactly one clock after the pending flag clears.
- R9: While `fifo_full` is high in an active burst, the acknowledge stays high and no word strobe occurs.
- R10: `rst` or `bus_rst` forces the idle state on the next clock, with the pending flag cleared and the acknowledge low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_rst | input | 1 | Disk bus held in reset |
| pend_set | input | 1 | Software write that sets the pending flag |
| cfg_dir | input | 1 | Direction field, 0 = drive to host |
| cfg_mode | input | 1 | 0 = multiword, 1 = ultra |
| drv_req | input | 1 | Drive DMA request |
| drv_intrq | input | 1 | Drive interrupt line |
| reg_acc_req | input | 1 | Host wants a drive register access |
| reg_acc_done | input | 1 | Register access finished |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| drv_ack | output | 1 | DMA acknowledge to the drive |
| word_stb | output | 1 | One-cycle strobe per word into the FIFO |
| paused | output | 1 | Burst suspended for a register access |
| pend_flag | output | 1 | Software pending flag |
| idle_sts | output | 1 | Transfer fully ended, safe to drain |
| eot_sts | output | 1 | Drive signalled end of transfer |
| ultra_sts | output | 1 | Mode captured for the current transfer |

## Verification
The hardest case to reach is the multiword divider's phase across a stall and a pause together. A FIFO-full stretch must keep the phase of the count, and a pause must restart it. The strobe total only shows this when the segment lengths are odd. The bench sweeps several parameters: both modes, leading and trailing segment lengths, with and without a full stall, and with and without a pause. It flips `cfg_mode` mid-burst and compares the total strobe count with an arithmetic prediction for each segment. Reset and bus reset are also applied in the middle of an active burst.

// File: rtl/ata_rx_dma_seq.sv
module ata_rx_dma_seq #(
  parameter int MW_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_rst,
  input  logic pend_set,
  input  logic cfg_dir,
  input  logic cfg_mode,
  input  logic drv_req,
  input  logic drv_intrq,
  input  logic reg_acc_req,
  input  logic reg_acc_done,
  input  logic fifo_full,
  output logic drv_ack,
  output logic word_stb,
  output logic paused,
  output logic pend_flag,
  output logic idle_sts,
  output logic eot_sts,
  output logic ultra_sts
);
  localparam int DW = (MW_DIV > 1) ? $clog2(MW_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(MW_DIV - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ACT, S_PAUSE, S_DONE} st_t;

  st_t st, st_nx;
  logic [DW-1:0] div;
  logic kill, arm, fin, qual;

  assign kill = rst | bus_rst;
  assign arm  = (st == S_IDLE) & pend_flag & ~cfg_dir;
  assign fin  = (st == S_ACT) & ~reg_acc_req & ~drv_req;
  assign qual = (st == S_ACT) & drv_req & ~fifo_full;

  assign drv_ack  = (st == S_ACT);
  assign paused   = (st == S_PAUSE);
  assign idle_sts = (st == S_IDLE);
  assign word_stb = qual & (ultra_sts | (div == DIV_LAST));

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (arm) st_nx = S_WAIT;
      S_WAIT:  if (drv_req) st_nx = S_ACT;
      S_ACT:   if (reg_acc_req) st_nx = S_PAUSE;
               else if (!drv_req) st_nx = S_DONE;
      S_PAUSE: if (reg_acc_done) st_nx = S_ACT;
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      st        <= S_IDLE;
      pend_flag <= 1'b0;
      eot_sts   <= 1'b0;
      ultra_sts <= 1'b0;
      div       <= '0;
    end else begin
      st <= st_nx;
      if (fin) pend_flag <= 1'b0;
      else if (pend_set) pend_flag <= 1'b1;
      if (arm) begin
        ultra_sts <= cfg_mode;
        eot_sts   <= 1'b0;
      end else if (drv_intrq) begin
        eot_sts <= 1'b1;
      end
      if (st != S_ACT) div <= '0;
      else if (qual) div <= (div == DIV_LAST) ? '0 : div + 1'b1;
    end
  end
endmodule

// File: rtl/ata_rx_dma_seq_chk.sv
module ata_rx_dma_seq_chk (
  input logic clk,
  input logic rst,
  input logic bus_rst,
  input logic drv_req,
  input logic reg_acc_req,
  input logic reg_acc_done,
  input logic fifo_full,
  input logic drv_ack,
  input logic word_stb,
  input logic paused,
  input logic pend_flag,
  input logic idle_sts
);
  AST_ACK_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst || bus_rst)
    drv_ack |-> pend_flag); // R1
  AST_STB_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst || bus_rst)
    word_stb |-> drv_ack); // R3
  AST_PAUSE_DROPS_ACK: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (drv_ack && reg_acc_req) |=> (!drv_ack && paused)); // R4
  AST_PAUSE_NO_STB: assert property (@(posedge clk) disable iff (rst || bus_rst)
    paused |-> !word_stb); // R4
  AST_RESUME_ACK: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (paused && reg_acc_done) |=> drv_ack); // R5
  AST_END_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (drv_ack && !drv_req && !reg_acc_req) |=> (!pend_flag && !drv_ack)); // R6
  AST_FULL_NO_STB: assert property (@(posedge clk) disable iff (rst || bus_rst)
    fifo_full |-> !word_stb); // R9
  AST_FULL_HOLDS_ACK: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (drv_ack && fifo_full && drv_req && !reg_acc_req) |=> drv_ack); // R9
  AST_BUS_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (idle_sts && !pend_flag && !drv_ack)); // R10
endmodule

bind ata_rx_dma_seq ata_rx_dma_seq_chk i_chk (
  .clk(clk), .rst(rst), .bus_rst(bus_rst), .drv_req(drv_req),
  .reg_acc_req(reg_acc_req), .reg_acc_done(reg_acc_done), .fifo_full(fifo_full),
  .drv_ack(drv_ack), .word_stb(word_stb), .paused(paused),
  .pend_flag(pend_flag), .idle_sts(idle_sts)
);

// File: tb/test_ata_rx_dma_seq.sv
module test_ata_rx_dma_seq;
  localparam int CLK_PER = 10;
  localparam int DIV = 2;

  logic clk = 0, rst = 1, bus_rst = 0, pend_set = 0, cfg_dir = 0, cfg_mode = 0;
  logic drv_req = 0, drv_intrq = 0, reg_acc_req = 0, reg_acc_done = 0, fifo_full = 0;
  logic drv_ack, word_stb, paused, pend_flag, idle_sts, eot_sts, ultra_sts;
  int checks = 0, fails = 0, stb_cnt = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;
  always @(negedge clk) if (word_stb) stb_cnt++;

  ata_rx_dma_seq #(.MW_DIV(DIV)) i_ata_rx_dma_seq (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .pend_set(pend_set), .cfg_dir(cfg_dir),
    .cfg_mode(cfg_mode), .drv_req(drv_req), .drv_intrq(drv_intrq),
    .reg_acc_req(reg_acc_req), .reg_acc_done(reg_acc_done), .fifo_full(fifo_full),
    .drv_ack(drv_ack), .word_stb(word_stb), .paused(paused), .pend_flag(pend_flag),
    .idle_sts(idle_sts), .eot_sts(eot_sts), .ultra_sts(ultra_sts));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int words(input int m, input int n);
    return m ? n : n / DIV;
  endfunction

  task automatic arm(input int m);
    cfg_dir = 0; cfg_mode = m[0]; pend_set = 1;
    cyc(1); pend_set = 0;
    chk("R1 pend set", pend_flag, 1);
    cyc(1);
    chk("R1 left idle", idle_sts, 0);
    chk("R3 no ack before req", drv_ack, 0);
    chk("R7 eot cleared on arm", eot_sts, 0);
  endtask

  task automatic xfer(input int m, input int k1, input int f, input int k2, input int p);
    int base, exp;
    arm(m);
    drv_req = 1; cyc(1);
    chk("R3 ack after req", drv_ack, 1);
    cfg_mode = ~m[0];
    base = stb_cnt;
    cyc(k1);
    if (f > 0) begin
      fifo_full = 1; cyc(f);
      chk("R9 ack held while full", drv_ack, 1);
      fifo_full = 0;
    end
    if (p) begin
      reg_acc_req = 1; cyc(1); reg_acc_req = 0;
      chk("R4 paused", paused, 1);
      chk("R4 ack dropped", drv_ack, 0);
      cyc(3);
      chk("R4 still paused", paused, 1);
      reg_acc_done = 1; cyc(1); reg_acc_done = 0;
      chk("R5 ack restored", drv_ack, 1);
      chk("R5 pause cleared", paused, 0);
    end
    cyc(k2);
    drv_req = 0; cyc(1);
    chk("R6 pend cleared", pend_flag, 0);
    chk("R6 ack dropped", drv_ack, 0);
    chk("R8 not yet idle", idle_sts, 0);
    exp = p ? words(m, k1 + 1) + words(m, k2) : words(m, k1 + k2);
    chk($sformatf("R2 strobes m=%0d k1=%0d f=%0d k2=%0d p=%0d", m, k1, f, k2, p),
        stb_cnt - base, exp);
    chk("R2 mode latched", ultra_sts, m);
    cyc(1);
    chk("R8 idle after done", idle_sts, 1);
  endtask

  initial begin
    cyc(2); rst = 0;
    chk("R10 reset idle", idle_sts, 1);
    chk("R10 reset ack", drv_ack, 0);
    chk("R10 reset pend", pend_flag, 0);
    chk("R7 reset eot", eot_sts, 0);

    for (int m = 0; m < 2; m++)
      for (int k1 = 0; k1 < 4; k1++)
        for (int k2 = 1; k2 < 4; k2++)
          for (int f = 0; f < 3; f += 2)
            for (int p = 0; p < 2; p++)
              xfer(m, k1, f, k2, p);

    cfg_dir = 1; pend_set = 1; drv_req = 1; cyc(1); pend_set = 0; cyc(3);
    chk("R1 dir=1 stays idle", idle_sts, 1);
    chk("R1 dir=1 no ack", drv_ack, 0);
    chk("R1 dir=1 pend kept", pend_flag, 1);
    bus_rst = 1; cyc(1); bus_rst = 0;
    chk("R10 bus reset clears pend", pend_flag, 0);
    cfg_dir = 0; cyc(3);
    chk("R1 no pend stays idle", idle_sts, 1);
    drv_req = 0;

    drv_intrq = 1; cyc(1); drv_intrq = 0;
    chk("R7 eot set", eot_sts, 1);
    cyc(3);
    chk("R7 eot sticky", eot_sts, 1);
    arm(1);

    drv_req = 1; cyc(1);
    chk("R3 ack before reset", drv_ack, 1);
    rst = 1; cyc(1); rst = 0;
    chk("R10 rst drops ack", drv_ack, 0);
    chk("R10 rst clears pend", pend_flag, 0);
    chk("R10 rst idle", idle_sts, 1);
    drv_req = 0;

    arm(0);
    drv_req = 1; cyc(1);
    bus_rst = 1; cyc(1); bus_rst = 0;
    chk("R10 bus reset drops ack", drv_ack, 0);
    chk("R10 bus reset idle", idle_sts, 1);
    drv_req = 0;

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule